// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block sits between the already-qualified digital fault comparators of a dual H-bridge motor driver and the bridge gate control. It decides when the bridge outputs may be driven and reports the most important active fault on two active-low flag pins. Every input is a plain level. Comparator hysteresis for over-voltage and over-temperature arrives as separate "above trip" and "below release" levels. The block adds the time qualification, the latching of a short, the release delay after a supply dip, and the flag priority. It runs from a 4 MHz clock, so one cycle is 250 ns.

A short on any half-bridge leg is accepted only after it persists for a qualifying run of cycles. It then stays latched until the inhibit input is pulled low or the block is reset. A phase whose current stays below the low-current level for a long run reports an open load, but the outputs stay on. Over-voltage or over-temperature turns the outputs off until the matching release level is reached. Undervoltage on either the supply or the regulator turns the outputs off without touching the flags, and the outputs come back only after a clean settling run. All pins are control or status levels, so there is no stream handshake and no back-pressure.

Top module: `mdf_fault_monitor`

## Requirements
- R1: When `oc_leg[i]` is high with `inhibit_n` high for OC_DELAY consecutive cycles, a short is latched. Any shorter burst leaves no trace, because the run counter restarts whenever the input drops.
- R2: A latched short stays latched while `inhibit_n` is high, even after every `oc_leg` bit has returned low. Driving `inhibit_n` low clears it.
- R3: While a short is latched, `out_en` is 0. When the short is the top fault, the flags are `ef1_n`=1 and `ef2_n`=0.
- R4: When `lowcur[p]` is high with `inhibit_n` high for OL_DELAY consecutive cycles, an open load is reported as `ef1_n`=0 and `ef2_n`=1, and `out_en` is unaffected. A run cut short restarts from zero.
- R5: Open load is not latched. Both flags return high two cycles after `lowcur` drops, when no other fault is active.
- R6: `ov_set` (or `ot_set`) sets an over-voltage (or over-temperature) state that holds until `ov_clr` (or `ot_clr`) is seen; the set level wins if both are high. While either state is set, `out_en` is 0 and both flags are 0.
- R7: The flags follow a fixed priority. Over-voltage or over-temperature gives 00. Otherwise open load gives `ef1_n`=0, `ef2_n`=1. Otherwise a short gives `ef1_n`=1, `ef2_n`=0. With none of these, the flags are 11.
- R8: `vbb_uv` or `vreg_uv` forces `out_en` to 0 and leaves the flags unchanged. `out_en` may return only after both inputs have been low for UV_DELAY consecutive cycles, counted from reset as well.
- R9: `inhibit_n` low forces `out_en` to 0 and holds the overcurrent and open-load run counters at zero, so no open load is reported while inhibited.
- R10: During and right after reset, `out_en` is 0 and both flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz block clock |
| rst_n | input | 1 | Power-on reset, active low |
| inhibit_n | input | 1 | Bridge enable; low means sleep and clears the short latch |
| oc_leg | input | NLEG | Overcurrent indication per half-bridge leg |
| lowcur | input | NPHASE | Current below the open-load level, per phase |
| ov_set | input | 1 | Supply above the over-voltage trip level |
| ov_clr | input | 1 | Supply below the over-voltage release level |
| ot_set | input | 1 | Die above the over-temperature trip level |
| ot_clr | input | 1 | Die below the over-temperature release level |
| vbb_uv | input | 1 | Motor supply undervoltage |
| vreg_uv | input | 1 | Gate regulator undervoltage |
| out_en | output | 1 | Bridge output enable (registered) |
| ef1_n | output | 1 | Error flag 1, active low (registered) |
| ef2_n | output | 1 | Error flag 2, active low (registered) |

## Verification
The bench builds the block with OC_DELAY=8, OL_DELAY=40 and UV_DELAY=20. These values keep the production qualification for shorts and shrink the open-load and release windows, so random segments of up to 50 cycles often cross both windows and also often stop one cycle short of them. This brings within reach the restart of a cut-short run, flag priority under several faults at once, and undervoltage dips in the middle of an open load. Directed cases pin the exact boundaries: 7 cycles versus 8 for a short, 39 cycles versus 40 for an open load, and the two-cycle open-load release.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
  // Flag code: bit 1 drives ef1_n, bit 0 drives ef2_n (both active low).
  typedef enum logic [1:0] {
    FLG_OVOT  = 2'b00,
    FLG_OPEN  = 2'b01,
    FLG_SHORT = 2'b10,
    FLG_NONE  = 2'b11
  } flag_code_t;

  function automatic flag_code_t pick_flag(input logic ovot, input logic open_ld,
                                           input logic short_ld);
    if (ovot)          return FLG_OVOT;
    else if (open_ld)  return FLG_OPEN;
    else if (short_ld) return FLG_SHORT;
    else               return FLG_NONE;
  endfunction
endpackage

// File: rtl/mdf_run_timer.sv
// Reports that 'run' has been high for LIMIT consecutive sampled cycles.
module mdf_run_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      hit <= hit | (cnt == LAST);
    end
  end

  AST_HIT_DROPS_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hit); // R5
endmodule

// File: rtl/mdf_flag_encoder.sv
module mdf_flag_encoder
  import mdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovot,
  input  logic open_ld,
  input  logic short_ld,
  output logic ef1_n,
  output logic ef2_n
);
  flag_code_t code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= FLG_NONE;
    else        code_q <= pick_flag(ovot, open_ld, short_ld);
  end

  assign ef1_n = code_q[1];
  assign ef2_n = code_q[0];

  AST_OVOT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovot |=> (!ef1_n && !ef2_n)); // R7
  AST_OPEN_OVER_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovot && open_ld) |=> (!ef1_n && ef2_n)); // R7
endmodule

// File: rtl/mdf_fault_monitor.sv
module mdf_fault_monitor #(
  parameter int NPHASE   = 2,
  parameter int OC_DELAY = 8,
  parameter int OL_DELAY = 3584,
  parameter int UV_DELAY = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit_n,
  input  logic [2*NPHASE-1:0] oc_leg,
  input  logic [NPHASE-1:0] lowcur,
  input  logic              ov_set,
  input  logic              ov_clr,
  input  logic              ot_set,
  input  logic              ot_clr,
  input  logic              vbb_uv,
  input  logic              vreg_uv,
  output logic              out_en,
  output logic              ef1_n,
  output logic              ef2_n
);
  localparam int NLEG = 2 * NPHASE;

  logic [NLEG-1:0]   oc_hit;
  logic [NPHASE-1:0] ol_hit;
  logic              uv_ok;
  logic              short_lat;
  logic              ov_lat;
  logic              ot_lat;

  // Per-leg short qualification
  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    mdf_run_timer #(.LIMIT(OC_DELAY)) u_oc (
      .clk(clk), .rst_n(rst_n), .run(oc_leg[g] & inhibit_n), .hit(oc_hit[g]));
  end

  // Per-phase open-load qualification
  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    mdf_run_timer #(.LIMIT(OL_DELAY)) u_ol (
      .clk(clk), .rst_n(rst_n), .run(lowcur[p] & inhibit_n), .hit(ol_hit[p]));
  end

  // Release delay after any undervoltage
  mdf_run_timer #(.LIMIT(UV_DELAY)) u_uv (
    .clk(clk), .rst_n(rst_n), .run(~(vbb_uv | vreg_uv)), .hit(uv_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_lat <= 1'b0;
      ov_lat    <= 1'b0;
      ot_lat    <= 1'b0;
      out_en    <= 1'b0;
    end else begin
      short_lat <= inhibit_n & (short_lat | (|oc_hit));
      ov_lat    <= ov_set | (ov_lat & ~ov_clr);
      ot_lat    <= ot_set | (ot_lat & ~ot_clr);
      out_en    <= inhibit_n & uv_ok & ~short_lat & ~ov_lat & ~ot_lat;
    end
  end

  mdf_flag_encoder u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovot(ov_lat | ot_lat), .open_ld(|ol_hit), .short_ld(short_lat),
    .ef1_n(ef1_n), .ef2_n(ef2_n));

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (short_lat && inhibit_n) |=> short_lat); // R2
  AST_SHORT_KILLS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    short_lat |=> !out_en); // R3
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |=> !out_en); // R9
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (vbb_uv || vreg_uv) |-> ##2 !out_en); // R8
  AST_OVOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_lat || ot_lat) |=> !out_en); // R6
endmodule

// File: tb/mdf_fault_monitor_bench.sv
module mdf_fault_monitor_bench;
  localparam int NPHASE = 2;
  localparam int NLEG   = 2 * NPHASE;
  localparam int OC_D   = 8;
  localparam int OL_D   = 40;
  localparam int UV_D   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inhibit_n = 1'b1;
  logic [NLEG-1:0] oc_leg = '0;
  logic [NPHASE-1:0] lowcur = '0;
  logic ov_set = 0, ov_clr = 0, ot_set = 0, ot_clr = 0, vbb_uv = 0, vreg_uv = 0;
  logic out_en, ef1_n, ef2_n;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  int oc_run [NLEG];
  int ol_run [NPHASE];
  int uv_run;
  bit m_short, m_ov, m_ot;
  logic [2:0] prev_e;
  int stab;

  always #4 clk = ~clk;

  mdf_fault_monitor #(.NPHASE(NPHASE), .OC_DELAY(OC_D), .OL_DELAY(OL_D), .UV_DELAY(UV_D))
  u_mdf_fault_monitor (
    .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .oc_leg(oc_leg), .lowcur(lowcur),
    .ov_set(ov_set), .ov_clr(ov_clr), .ot_set(ot_set), .ot_clr(ot_clr),
    .vbb_uv(vbb_uv), .vreg_uv(vreg_uv), .out_en(out_en), .ef1_n(ef1_n), .ef2_n(ef2_n));

  function automatic bit any_ol();
    for (int p = 0; p < NPHASE; p++) if (ol_run[p] >= OL_D) return 1'b1;
    return 1'b0;
  endfunction

  // expected flags {ef1_n, ef2_n} by the priority of R7
  function automatic logic [1:0] exp_flags();
    if (m_ov || m_ot) return 2'b00;
    if (any_ol())     return 2'b01;
    if (m_short)      return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic exp_en();
    return inhibit_n && (uv_run >= UV_D) && !m_short && !m_ov && !m_ot;
  endfunction

  task automatic model_update();
    logic [2:0] e;
    if (!rst_n) begin
      foreach (oc_run[i]) oc_run[i] = 0;
      foreach (ol_run[i]) ol_run[i] = 0;
      uv_run = 0; m_short = 0; m_ov = 0; m_ot = 0;
    end else begin
      for (int i = 0; i < NLEG; i++) begin
        oc_run[i] = (oc_leg[i] && inhibit_n) ? oc_run[i] + 1 : 0;
        if (oc_run[i] >= OC_D) m_short = 1;
      end
      if (!inhibit_n) m_short = 0;
      for (int p = 0; p < NPHASE; p++)
        ol_run[p] = (lowcur[p] && inhibit_n) ? ((ol_run[p] < 100000) ? ol_run[p] + 1 : ol_run[p]) : 0;
      uv_run = (!vbb_uv && !vreg_uv) ? ((uv_run < 100000) ? uv_run + 1 : uv_run) : 0;
      m_ov = ov_set || (m_ov && !ov_clr);
      m_ot = ot_set || (m_ot && !ot_clr);
    end
    e = {exp_en(), exp_flags()};
    if (e == prev_e) stab++; else stab = 0;
    prev_e = e;
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {out_en,ef1_n,ef2_n} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk(tag, {out_en, ef1_n, ef2_n}, {exp_en(), exp_flags()});
  endtask

  task automatic quiet();
    oc_leg = '0; lowcur = '0; ov_set = 0; ov_clr = 1; ot_set = 0; ot_clr = 1;
    vbb_uv = 0; vreg_uv = 0; inhibit_n = 1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    prev_e = 3'b011; stab = 0;
    @(negedge clk);
    tick(3);
    chk("R10 reset state", {out_en, ef1_n, ef2_n}, 3'b011);
    rst_n = 1'b1;
    quiet();
    tick(1);
    chk("R10 just after reset", {out_en, ef1_n, ef2_n}, 3'b011);
    tick(UV_D - 4);
    chk("R8 release delay not yet over", {out_en, ef1_n, ef2_n}, 3'b011);
    tick(8);
    chk("R8 outputs on after clean run", {out_en, ef1_n, ef2_n}, 3'b111);

    // R1: 7-cycle burst leaves no short
    oc_leg = 4'b0100; tick(OC_D - 1); oc_leg = '0; tick(6);
    chk("R1 short burst ignored", {out_en, ef1_n, ef2_n}, 3'b111);
    // R1/R3: full run latches
    oc_leg = 4'b0010; tick(OC_D); oc_leg = '0; tick(6);
    chk("R1 R3 short latched", {out_en, ef1_n, ef2_n}, 3'b010);
    tick(30);
    chk("R2 short held after oc clears", {out_en, ef1_n, ef2_n}, 3'b010);
    inhibit_n = 0; tick(3);
    chk("R9 inhibit low disables", {out_en, ef1_n, ef2_n}, 3'b011);
    inhibit_n = 1; tick(5);
    chk("R2 inhibit cleared short", {out_en, ef1_n, ef2_n}, 3'b111);

    // R4: 39 cycles, restart, then full run
    lowcur = 2'b01; tick(OL_D - 1); lowcur = 2'b00; tick(1); lowcur = 2'b01; tick(OL_D - 1);
    chk("R4 cut-short run restarts", {out_en, ef1_n, ef2_n}, 3'b111);
    tick(4);
    chk("R4 open load flagged, outputs on", {out_en, ef1_n, ef2_n}, 3'b101);
    lowcur = 2'b00; tick(2);
    chk("R5 open load released in two cycles", {out_en, ef1_n, ef2_n}, 3'b111);

    // R7 priority ladder
    lowcur = 2'b10; oc_leg = 4'b1000; tick(OL_D + 4); oc_leg = '0; tick(2);
    chk("R7 open load over short", {out_en, ef1_n, ef2_n}, 3'b001);
    ov_clr = 0; ov_set = 1; tick(1); ov_set = 0; tick(4);
    chk("R6 R7 over-voltage wins", {out_en, ef1_n, ef2_n}, 3'b000);
    tick(10);
    chk("R6 held between trip and release", {out_en, ef1_n, ef2_n}, 3'b000);
    ov_clr = 1; tick(4);
    chk("R6 released back to open load", {out_en, ef1_n, ef2_n}, 3'b001);
    lowcur = 2'b00; tick(4);
    chk("R7 short after open load clears", {out_en, ef1_n, ef2_n}, 3'b010);
    inhibit_n = 0; tick(2); inhibit_n = 1; tick(4);
    ot_clr = 1; ot_set = 1; tick(3); ot_set = 0; tick(3);
    chk("R6 set wins over release", {out_en, ef1_n, ef2_n}, 3'b111);

    // R8: undervoltage during open load leaves flags
    lowcur = 2'b01; tick(OL_D + 4); vreg_uv = 1; tick(4);
    chk("R8 uv off, flags kept", {out_en, ef1_n, ef2_n}, 3'b001);
    vreg_uv = 0; tick(UV_D - 3);
    chk("R8 still off inside release delay", {out_en, ef1_n, ef2_n}, 3'b001);
    tick(6);
    chk("R8 back on after release delay", {out_en, ef1_n, ef2_n}, 3'b101);
    // R9: no open load while inhibited
    inhibit_n = 0; tick(OL_D + 6);
    chk("R9 no open load in sleep", {out_en, ef1_n, ef2_n}, 3'b011);
    quiet(); tick(30);
    chk_model("R7 model agrees after directed part");

    // constrained random segments
    for (int s = 0; s < 400; s++) begin
      int len;
      for (int i = 0; i < NLEG; i++) oc_leg[i] = ($urandom % 6) == 0;
      for (int p = 0; p < NPHASE; p++) lowcur[p] = ($urandom % 2) == 0;
      ov_set = ($urandom % 12) == 0; ov_clr = ($urandom % 3) == 0;
      ot_set = ($urandom % 12) == 0; ot_clr = ($urandom % 3) == 0;
      vbb_uv = ($urandom % 10) == 0; vreg_uv = ($urandom % 10) == 0;
      inhibit_n = ($urandom % 10) != 0;
      len = 1 + int'($urandom % 50);
      tick(len);
      if (stab >= 4) chk_model("R1 R4 R6 R7 R8 random segment");
    end
    summary();
  end
endmodule